// File: doc/BRIEF.md
# Source Route Computation Unit

This unit sits inside a network interface and prepares a source-routed header for each outgoing request. It works in two registered stages. The first stage compares the request address against a set of address windows and resolves the destination endpoint ID. The second stage uses that result to pick a precomputed route from a route table. The route table arrives on an input port, so system integration can fill it in without changing the RTL.

The route is a bit-vector built from fixed-width hop fields. The router at each hop reads the lowest field as its output-port choice, then shifts the vector right by one field width before forwarding it. The next router therefore finds its own field at the bottom. The unit includes this per-hop step as a separate registered path. A router-side block, or a bench, can use it to consume the route one hop at a time.

Destination IDs are the matched window index plus a global ID offset. An address that matches no window is sent to a fixed error destination, takes the last table entry as its route, and raises a miss flag.

Top module: `srcroute_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid_o`, `miss_o`, `dst_id_o`, `route_o`, `hop_port_o` and `hop_route_o` are all zero.
- R2: A request with address inside window i gives `dst_id_o` = i + IdOffset. With the defaults IdOffset = 2, so window 0 gives ID 2.
- R3: When several windows contain the address, the lowest-index window wins.
- R4: For a matched window i, `route_o` equals table slice `route_table_i[i*RouteW +: RouteW]`.
- R5: An address matching no window gives `dst_id_o` = ErrId (default 15), `miss_o` = 1, and `route_o` = table slice number NumWindows, the last entry.
- R6: `rsp_valid_o` rises exactly two clock cycles after a cycle with `req_valid_i` high and is low otherwise. While it is low, `dst_id_o`, `route_o` and `miss_o` keep their last values.
- R7: One cycle after `hop_route_i` is presented, `hop_port_o` equals its lowest PortW bits and `hop_route_o` equals it shifted right by PortW with zero fill. PortW = ceil(log2(RouterPorts)), which is 3 for 5 ports.
- R8: A window covers start <= address < end, so its start is inclusive and its end exclusive. A window with start >= end never matches.
- R9: The table is read at lookup time, so a changed table entry takes effect on the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request address is valid this cycle |
| req_addr_i | input | AddrW | Request address |
| win_start_i | input | NumWindows*AddrW | Inclusive window starts, window i at slice i |
| win_end_i | input | NumWindows*AddrW | Exclusive window ends, window i at slice i |
| route_table_i | input | (NumWindows+1)*RouteW | Route per window plus the error route at the top slice |
| rsp_valid_o | output | 1 | Result valid |
| dst_id_o | output | IdW | Resolved destination ID |
| route_o | output | RouteW | Route vector for the header |
| miss_o | output | 1 | Address matched no window |
| hop_route_i | input | RouteW | Route vector arriving at a hop |
| hop_port_o | output | PortW | Output-port choice of this hop |
| hop_route_o | output | RouteW | Route vector forwarded to the next hop |

## Verification
The bench uses the defaults: a 16-bit address, four windows, ID offset 2, error ID 15, five router ports and four hops. With five ports the hop field is 3 bits and does not fill a power of two, so the shift amount and the zero fill at the top are both exercised. The windows overlap, and one of them is empty, which tests lowest-index priority, the inclusive and exclusive bounds, and the miss path. Rewriting a table entry at run time shows that the table is read from the port at lookup time.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int unsigned WideW = 64;

  function automatic logic in_window(input logic [WideW-1:0] addr,
                                     input logic [WideW-1:0] lo,
                                     input logic [WideW-1:0] hi);
    return (addr >= lo) && (addr < hi);
  endfunction
endpackage

// File: rtl/srt_range_map.sv
module srt_range_map #(
  parameter int unsigned AddrW      = 16,
  parameter int unsigned NumWindows = 4,
  parameter int unsigned IdxW       = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        vld_i,
  input  logic [AddrW-1:0]            addr_i,
  input  logic [NumWindows*AddrW-1:0] start_i,
  input  logic [NumWindows*AddrW-1:0] end_i,
  output logic                        s1_vld_o,
  output logic                        s1_miss_o,
  output logic [IdxW-1:0]             s1_idx_o
);
  logic [NumWindows-1:0] hit;
  logic [IdxW-1:0]       sel;
  logic                  any_hit;

  for (genvar g = 0; g < NumWindows; g++) begin : g_cmp
    assign hit[g] = srt_pkg::in_window(srt_pkg::WideW'(addr_i),
                                       srt_pkg::WideW'(start_i[g*AddrW +: AddrW]),
                                       srt_pkg::WideW'(end_i[g*AddrW +: AddrW]));
  end

  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = NumWindows - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel     = IdxW'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s1_vld_o  <= 1'b0;
      s1_miss_o <= 1'b0;
      s1_idx_o  <= '0;
    end else begin
      s1_vld_o <= vld_i;
      if (vld_i) begin
        s1_miss_o <= !any_hit;
        s1_idx_o  <= sel;
      end
    end
  end

  function automatic logic win_hit(input int unsigned k, input logic [AddrW-1:0] a,
                                   input logic [NumWindows*AddrW-1:0] st,
                                   input logic [NumWindows*AddrW-1:0] en);
    return (a >= st[k*AddrW +: AddrW]) && (a < en[k*AddrW +: AddrW]);
  endfunction

  function automatic logic lowest_ok(input logic [IdxW-1:0] idx, input logic [AddrW-1:0] a,
                                     input logic [NumWindows*AddrW-1:0] st,
                                     input logic [NumWindows*AddrW-1:0] en);
    logic ok;
    ok = win_hit(int'(idx), a, st, en);
    for (int k = 0; k < NumWindows; k++)
      if (k < int'(idx) && win_hit(k, a, st, en)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic none_hit(input logic [AddrW-1:0] a,
                                    input logic [NumWindows*AddrW-1:0] st,
                                    input logic [NumWindows*AddrW-1:0] en);
    logic none;
    none = 1'b1;
    for (int k = 0; k < NumWindows; k++)
      if (win_hit(k, a, st, en)) none = 1'b0;
    return none;
  endfunction

  assert_lowest_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_i |=> (s1_miss_o || lowest_ok(s1_idx_o, $past(addr_i), $past(start_i), $past(end_i))));

  assert_miss_no_window_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_i |=> (!s1_miss_o || none_hit($past(addr_i), $past(start_i), $past(end_i))));
endmodule

// File: rtl/srt_route_lookup.sv
module srt_route_lookup #(
  parameter int unsigned NumWindows = 4,
  parameter int unsigned IdxW       = 2,
  parameter int unsigned IdW        = 4,
  parameter int unsigned IdOffset   = 2,
  parameter int unsigned ErrId      = 15,
  parameter int unsigned RouteW     = 12,
  localparam int unsigned Entries   = NumWindows + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      s1_vld_i,
  input  logic                      s1_miss_i,
  input  logic [IdxW-1:0]           s1_idx_i,
  input  logic [Entries*RouteW-1:0] table_i,
  output logic                      vld_o,
  output logic                      miss_o,
  output logic [IdW-1:0]            dst_o,
  output logic [RouteW-1:0]         route_o
);
  logic [RouteW-1:0] tbl [Entries];

  for (genvar e = 0; e < Entries; e++) begin : g_row
    assign tbl[e] = table_i[e*RouteW +: RouteW];
  end

  logic [RouteW-1:0] row_sel;
  logic [IdW-1:0]    id_sel;

  always_comb begin
    row_sel = s1_miss_i ? tbl[NumWindows] : tbl[s1_idx_i];
    id_sel  = s1_miss_i ? IdW'(ErrId) : IdW'(s1_idx_i) + IdW'(IdOffset);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_o   <= 1'b0;
      miss_o  <= 1'b0;
      dst_o   <= '0;
      route_o <= '0;
    end else begin
      vld_o <= s1_vld_i;
      if (s1_vld_i) begin
        miss_o  <= s1_miss_i;
        dst_o   <= id_sel;
        route_o <= row_sel;
      end
    end
  end

  assert_table_route_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (s1_vld_i && !s1_miss_i) |=> (route_o == $past(tbl[s1_idx_i])));

  assert_error_route_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (s1_vld_i && s1_miss_i) |=> (route_o == $past(tbl[NumWindows])));
endmodule

// File: rtl/srt_hop_step.sv
module srt_hop_step #(
  parameter int unsigned PortW  = 3,
  parameter int unsigned RouteW = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [RouteW-1:0] route_i,
  output logic [PortW-1:0]  port_o,
  output logic [RouteW-1:0] route_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      port_o  <= '0;
      route_o <= '0;
    end else begin
      port_o  <= route_i[PortW-1:0];
      route_o <= route_i >> PortW;
    end
  end

  assert_hop_consume_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ({route_o[RouteW-PortW-1:0], port_o} == $past(route_i)) &&
             (route_o[RouteW-1:RouteW-PortW] == '0));
endmodule

// File: rtl/srcroute_unit.sv
module srcroute_unit #(
  parameter int unsigned AddrW       = 16,
  parameter int unsigned NumWindows  = 4,
  parameter int unsigned IdW         = 4,
  parameter int unsigned IdOffset    = 2,
  parameter int unsigned ErrId       = 15,
  parameter int unsigned RouterPorts = 5,
  parameter int unsigned MaxHops     = 4,
  localparam int unsigned IdxW       = (NumWindows > 1) ? $clog2(NumWindows) : 1,
  localparam int unsigned PortW      = $clog2(RouterPorts),
  localparam int unsigned RouteW     = PortW * MaxHops
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic                              req_valid_i,
  input  logic [AddrW-1:0]                  req_addr_i,
  input  logic [NumWindows*AddrW-1:0]       win_start_i,
  input  logic [NumWindows*AddrW-1:0]       win_end_i,
  input  logic [(NumWindows+1)*RouteW-1:0]  route_table_i,
  output logic                              rsp_valid_o,
  output logic [IdW-1:0]                    dst_id_o,
  output logic [RouteW-1:0]                 route_o,
  output logic                              miss_o,
  input  logic [RouteW-1:0]                 hop_route_i,
  output logic [PortW-1:0]                  hop_port_o,
  output logic [RouteW-1:0]                 hop_route_o
);
  logic            s1_vld;
  logic            s1_miss;
  logic [IdxW-1:0] s1_idx;

  srt_range_map #(.AddrW(AddrW), .NumWindows(NumWindows), .IdxW(IdxW)) u_map (
    .clk_i, .rst_i,
    .vld_i    (req_valid_i),
    .addr_i   (req_addr_i),
    .start_i  (win_start_i),
    .end_i    (win_end_i),
    .s1_vld_o (s1_vld),
    .s1_miss_o(s1_miss),
    .s1_idx_o (s1_idx)
  );

  srt_route_lookup #(.NumWindows(NumWindows), .IdxW(IdxW), .IdW(IdW), .IdOffset(IdOffset),
                     .ErrId(ErrId), .RouteW(RouteW)) u_lookup (
    .clk_i, .rst_i,
    .s1_vld_i (s1_vld),
    .s1_miss_i(s1_miss),
    .s1_idx_i (s1_idx),
    .table_i  (route_table_i),
    .vld_o    (rsp_valid_o),
    .miss_o   (miss_o),
    .dst_o    (dst_id_o),
    .route_o  (route_o)
  );

  srt_hop_step #(.PortW(PortW), .RouteW(RouteW)) u_hop (
    .clk_i, .rst_i,
    .route_i(hop_route_i),
    .port_o (hop_port_o),
    .route_o(hop_route_o)
  );

  assert_valid_two_cycles_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    req_valid_i |=> ##1 rsp_valid_o);

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !req_valid_i |=> ##1 !rsp_valid_o);

  assert_miss_dest_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_valid_o && miss_o) |-> (dst_id_o == IdW'(ErrId)));

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !s1_vld |=> ($stable(dst_id_o) && $stable(route_o) && $stable(miss_o)));
endmodule

// File: tb/tb_srcroute_unit.sv
module tb_srcroute_unit;
  localparam int AW = 16, NW = 4, IW = 4, PW = 3, RW = 12;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [NW*AW-1:0] wstart, wend;
  logic [(NW+1)*RW-1:0] rtab;
  logic rsp_valid, miss;
  logic [IW-1:0] dst;
  logic [RW-1:0] route, hop_in, hop_out;
  logic [PW-1:0] hop_port;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  srcroute_unit dut (
    .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .win_start_i(wstart), .win_end_i(wend), .route_table_i(rtab),
    .rsp_valid_o(rsp_valid), .dst_id_o(dst), .route_o(route), .miss_o(miss),
    .hop_route_i(hop_in), .hop_port_o(hop_port), .hop_route_o(hop_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(input string req, input logic [AW-1:0] a, input logic [IW-1:0] e_dst,
                        input logic e_miss, input logic [RW-1:0] e_route);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " dst"}, 32'(dst), 32'(e_dst));
    chk({req, " miss"}, 32'(miss), 32'(e_miss));
    chk({req, " route"}, 32'(route), 32'(e_route));
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; hop_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid", 32'(rsp_valid), 0);
    chk("R1 dst", 32'(dst), 0);
    chk("R1 route", 32'(route), 0);
    chk("R1 miss", 32'(miss), 0);
    chk("R1 hop port", 32'(hop_port), 0);
    chk("R1 hop route", 32'(hop_out), 0);
  endtask

  task automatic t_windows;
    lookup("R2 R8 start inclusive", 16'h1000, 4'd2, 1'b0, 12'hA53);
    lookup("R3 overlap lowest", 16'h1FFF, 4'd2, 1'b0, 12'hA53);
    lookup("R8 end exclusive R4", 16'h2000, 4'd3, 1'b0, 12'h1C7);
    lookup("R2 window3", 16'h9000, 4'd5, 1'b0, 12'h6E9);
  endtask

  task automatic t_miss;
    lookup("R5 R8 empty window", 16'h4000, 4'd15, 1'b1, 12'hFFF);
    lookup("R5 top end exclusive", 16'hFFFF, 4'd15, 1'b1, 12'hFFF);
    lookup("R5 below all", 16'h0004, 4'd15, 1'b1, 12'hFFF);
  endtask

  task automatic t_timing;
    lookup("R6 setup", 16'h2800, 4'd3, 1'b0, 12'h1C7);
    @(negedge clk);
    chk("R6 idle valid", 32'(rsp_valid), 0);
    chk("R6 hold dst", 32'(dst), 32'd3);
    chk("R6 hold route", 32'(route), 32'h1C7);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h1200;
    @(negedge clk);
    req_addr = 16'h8000;
    chk("R6 one cycle later", 32'(rsp_valid), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 b2b first valid", 32'(rsp_valid), 1);
    chk("R6 b2b first dst", 32'(dst), 32'd2);
    @(negedge clk);
    chk("R6 b2b second valid", 32'(rsp_valid), 1);
    chk("R6 b2b second dst", 32'(dst), 32'd5);
    chk("R6 b2b second route", 32'(route), 32'h6E9);
  endtask

  task automatic t_table;
    rtab[3*RW +: RW] = 12'h0F0;
    lookup("R9 new table entry", 16'h9000, 4'd5, 1'b0, 12'h0F0);
  endtask

  task automatic t_hop;
    @(negedge clk);
    hop_in = 12'hA53;
    @(negedge clk);
    chk("R7 hop1 port", 32'(hop_port), 32'd3);
    chk("R7 hop1 route", 32'(hop_out), 32'h14A);
    hop_in = hop_out;
    @(negedge clk);
    chk("R7 hop2 port", 32'(hop_port), 32'd2);
    chk("R7 hop2 route", 32'(hop_out), 32'h029);
    hop_in = 12'hFFF;
    @(negedge clk);
    chk("R7 zero fill", 32'(hop_out), 32'h1FF);
  endtask

  initial begin
    wstart = {16'h8000, 16'h4000, 16'h1800, 16'h1000};
    wend   = {16'hFFFF, 16'h4000, 16'h3000, 16'h2000};
    rtab   = {12'hFFF, 12'h6E9, 12'h2B4, 12'h1C7, 12'hA53};
    t_reset();
    t_windows();
    t_miss();
    t_timing();
    t_table();
    t_hop();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule